// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block holds the per-entry settings of a physical memory protection unit: one configuration byte and one raw address register for each entry. Software-side logic presents indexed write requests on a single-cycle port, selecting either the configuration byte or the address register of one entry. The bank accepts or refuses each request in the same cycle, according to the entry lock rules. It also keeps registered summary status: how many rules are active, and whether any entry is locked. A separate permission checker reads every entry at once through flat configuration and address buses.

A synchronous reset disables and unlocks every entry. It keeps the read, write and execute permission bits and the address registers as they were. A combined "check required" output tells the access path whether the protection table has to be consulted for the current privilege level.

Top module: `pmpb_bank`

## Requirements
- R1: A write request whose index is equal to or greater than NUM_ENTRIES is refused (`wr_accept` low) and changes no register.
- R2: The configuration byte has this layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 naturally aligned 4 bytes, 3 naturally aligned power of two), bit 7 lock. A configuration write (`wr_sel`=0) to an entry whose current lock bit is 1 is refused, and the byte keeps its value.
- R3: An address write (`wr_sel`=1) to an entry whose own lock bit is 1 is refused, and the address keeps its value.
- R4: An address write to entry i is also refused when entry i+1 is locked and in top-of-range mode. It is accepted when entry i+1 is locked in another mode, or in top-of-range mode but unlocked. The highest entry has no such neighbour.
- R5: `wr_accept` is given combinationally in the request cycle. An accepted write appears on `cfg_bus` or `addr_bus` after the next rising clock edge. Slot i is at bits [i*8+7:i*8] and [i*ADDR_W+ADDR_W-1:i*ADDR_W].
- R6: `active_rules` is registered and always equals the number of entries whose mode field is not off, including right after an accepted write.
- R7: `any_locked` is registered and always equals the OR of all entries' lock bits.
- R8: While `rst` is high, no write is accepted. After reset, every mode field and lock bit is 0, the read/write/execute bits and address registers keep their previous values, and `active_rules` and `any_locked` are 0.
- R9: `check_req` is high exactly when `active_rules` is nonzero and either `priv_machine` is low or `any_locked` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request valid |
| wr_sel | input | 1 | 0 selects the configuration byte, 1 selects the address register |
| wr_index | input | IDX_W | Target entry |
| wr_data | input | ADDR_W | Write data (low 8 bits used for configuration) |
| priv_machine | input | 1 | Current privilege is machine mode |
| wr_accept | output | 1 | Request accepted this cycle |
| cfg_bus | output | NUM_ENTRIES*8 | All configuration bytes |
| addr_bus | output | NUM_ENTRIES*ADDR_W | All raw address registers |
| active_rules | output | CNT_W | Number of entries not in off mode |
| any_locked | output | 1 | Some entry is locked |
| check_req | output | 1 | Protection table must be consulted |

## Verification
The accept response is combinational, so the bench drives each request just after a falling edge and reads `wr_accept` one time step later, in the same cycle. Register contents and both summary outputs change on the single rising edge that follows. They are therefore read at the next falling edge, one cycle after the request. `check_req` follows `priv_machine` without delay and is read shortly after each privilege change. Refused and reset cases compare the complete buses before and after the stimulus.

// File: rtl/pmpb_pkg.sv
package pmpb_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef struct packed {
    logic        lock;
    logic [1:0]  spare;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;

  localparam int CFG_W = 8;

  function automatic entry_cfg_t cfg_reset_value(input entry_cfg_t c);
    entry_cfg_t o;
    o      = c;
    o.lock = 1'b0;
    o.mode = MODE_OFF;
    return o;
  endfunction

endpackage

// File: rtl/pmpb_entry.sv
module pmpb_entry
  import pmpb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] wr_data,
  output entry_cfg_t        cfg_q,
  output entry_cfg_t        cfg_d,
  output logic [ADDR_W-1:0] addr_q
);

  always_comb begin
    if (rst)
      cfg_d = cfg_reset_value(cfg_q);
    else if (cfg_we)
      cfg_d = entry_cfg_t'(wr_data[CFG_W-1:0]);
    else
      cfg_d = cfg_q;
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  always_ff @(posedge clk) begin
    if (addr_we)
      addr_q <= wr_data;
  end

endmodule

// File: rtl/pmpb_wr_ctrl.sv
module pmpb_wr_ctrl
  import pmpb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 5
) (
  input  logic                   rst,
  input  logic                   wr_valid,
  input  logic                   wr_sel,
  input  logic [IDX_W-1:0]       wr_index,
  input  entry_cfg_t             cfg_q [NUM_ENTRIES],
  output logic                   wr_accept,
  output logic [NUM_ENTRIES-1:0] cfg_we,
  output logic [NUM_ENTRIES-1:0] addr_we
);

  logic [NUM_ENTRIES-1:0] hit;
  logic [NUM_ENTRIES-1:0] own_lock;
  logic [NUM_ENTRIES-1:0] upper_guard;
  logic                   idx_ok;
  logic                   tgt_locked;
  logic                   tgt_guarded;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    assign hit[i]      = (wr_index == SLOT);
    assign own_lock[i] = cfg_q[i].lock;
    if (i < NUM_ENTRIES - 1) begin : g_upper
      assign upper_guard[i] = cfg_q[i+1].lock && (cfg_q[i+1].mode == MODE_TOR);
    end else begin : g_top
      assign upper_guard[i] = 1'b0;
    end
  end

  assign idx_ok      = (int'(wr_index) < NUM_ENTRIES);
  assign tgt_locked  = |(hit & own_lock);
  assign tgt_guarded = |(hit & upper_guard);

  always_comb begin
    wr_accept = wr_valid && !rst && idx_ok && !tgt_locked;
    if (wr_sel && tgt_guarded)
      wr_accept = 1'b0;
  end

  assign cfg_we  = (wr_accept && !wr_sel) ? hit : '0;
  assign addr_we = (wr_accept &&  wr_sel) ? hit : '0;

endmodule

// File: rtl/pmpb_summary.sv
module pmpb_summary
  import pmpb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int CNT_W       = 5
) (
  input  logic             clk,
  input  entry_cfg_t       cfg_d [NUM_ENTRIES],
  output logic [CNT_W-1:0] active_rules,
  output logic             any_locked
);

  logic [CNT_W-1:0] cnt_nxt;
  logic             lock_nxt;

  always_comb begin
    cnt_nxt  = '0;
    lock_nxt = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      cnt_nxt  = cnt_nxt + CNT_W'(cfg_d[i].mode != MODE_OFF);
      lock_nxt = lock_nxt | cfg_d[i].lock;
    end
  end

  always_ff @(posedge clk) begin
    active_rules <= cnt_nxt;
    any_locked   <= lock_nxt;
  end

endmodule

// File: rtl/pmpb_bank.sv
module pmpb_bank
  import pmpb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 5,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_valid,
  input  logic                          wr_sel,
  input  logic [IDX_W-1:0]              wr_index,
  input  logic [ADDR_W-1:0]             wr_data,
  input  logic                          priv_machine,
  output logic                          wr_accept,
  output logic [NUM_ENTRIES*8-1:0]      cfg_bus,
  output logic [NUM_ENTRIES*ADDR_W-1:0] addr_bus,
  output logic [CNT_W-1:0]              active_rules,
  output logic                          any_locked,
  output logic                          check_req
);

  entry_cfg_t             cfg_q [NUM_ENTRIES];
  entry_cfg_t             cfg_d [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] cfg_we;
  logic [NUM_ENTRIES-1:0] addr_we;

  pmpb_wr_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) u_wr_ctrl (
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_index (wr_index),
    .cfg_q    (cfg_q),
    .wr_accept(wr_accept),
    .cfg_we   (cfg_we),
    .addr_we  (addr_we)
  );

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    pmpb_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk    (clk),
      .rst    (rst),
      .cfg_we (cfg_we[i]),
      .addr_we(addr_we[i]),
      .wr_data(wr_data),
      .cfg_q  (cfg_q[i]),
      .cfg_d  (cfg_d[i]),
      .addr_q (addr_bus[i*ADDR_W +: ADDR_W])
    );
    assign cfg_bus[i*8 +: 8] = cfg_q[i];
  end

  pmpb_summary #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .CNT_W      (CNT_W)
  ) u_summary (
    .clk         (clk),
    .cfg_d       (cfg_d),
    .active_rules(active_rules),
    .any_locked  (any_locked)
  );

  assign check_req = (active_rules != '0) && (!priv_machine || any_locked);

endmodule

// File: rtl/pmpb_bank_chk.sv
module pmpb_bank_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 5,
  parameter int CNT_W       = 5
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_valid,
  input logic                          wr_sel,
  input logic [IDX_W-1:0]              wr_index,
  input logic                          priv_machine,
  input logic                          wr_accept,
  input logic [NUM_ENTRIES*8-1:0]      cfg_bus,
  input logic [CNT_W-1:0]              active_rules,
  input logic                          any_locked,
  input logic                          check_req
);

  function automatic logic lock_at(input logic [IDX_W-1:0] idx);
    logic res;
    res = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (int'(idx) == i) res = cfg_bus[i*8+7];
    return res;
  endfunction

  function automatic logic tor_locked_at(input int idx);
    logic res;
    res = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (idx == i) res = cfg_bus[i*8+7] && (cfg_bus[i*8+3 +: 2] == 2'd1);
    return res;
  endfunction

  function automatic int live_modes();
    int n;
    n = 0;
    for (int i = 0; i < NUM_ENTRIES; i++)
      if (cfg_bus[i*8+3 +: 2] != 2'd0) n++;
    return n;
  endfunction

  function automatic logic lock_or();
    logic res;
    res = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) res = res | cfg_bus[i*8+7];
    return res;
  endfunction

  p_oob_refused_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && int'(wr_index) >= NUM_ENTRIES) |-> !wr_accept);

  p_cfg_lock_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_sel && lock_at(wr_index)) |-> !wr_accept);

  p_locked_cfg_held_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_sel && lock_at(wr_index)) |=> $stable(cfg_bus));

  p_addr_own_lock_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_sel && lock_at(wr_index)) |-> !wr_accept);

  p_addr_upper_tor_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_sel && tor_locked_at(int'(wr_index) + 1)) |-> !wr_accept);

  p_count_r6: assert property (@(posedge clk) disable iff (rst)
    int'(active_rules) == live_modes());

  p_lock_or_r7: assert property (@(posedge clk) disable iff (rst)
    any_locked == lock_or());

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (active_rules == '0 && !any_locked));

  p_no_accept_in_reset_r8: assert property (@(posedge clk)
    rst |-> !wr_accept);

  p_idle_check_r9: assert property (@(posedge clk) disable iff (rst)
    (active_rules == '0) |-> !check_req);

  p_user_check_r9: assert property (@(posedge clk) disable iff (rst)
    (active_rules != '0 && !priv_machine) |-> check_req);

endmodule

bind pmpb_bank pmpb_bank_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .CNT_W      (CNT_W)
) u_pmpb_bank_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_valid    (wr_valid),
  .wr_sel      (wr_sel),
  .wr_index    (wr_index),
  .priv_machine(priv_machine),
  .wr_accept   (wr_accept),
  .cfg_bus     (cfg_bus),
  .active_rules(active_rules),
  .any_locked  (any_locked),
  .check_req   (check_req)
);

// File: tb/pmpb_bank_bench.sv
module pmpb_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int CW = $clog2(N + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            wr_valid = 1'b0;
  logic            wr_sel = 1'b0;
  logic [IW-1:0]   wr_index = '0;
  logic [AW-1:0]   wr_data = '0;
  logic            priv_machine = 1'b1;
  logic            wr_accept;
  logic [N*8-1:0]  cfg_bus;
  logic [N*AW-1:0] addr_bus;
  logic [CW-1:0]   active_rules;
  logic            any_locked;
  logic            check_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmpb_bank #(.NUM_ENTRIES(N), .ADDR_W(AW), .IDX_W(IW)) u_pmpb_bank (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_sel(wr_sel),
    .wr_index(wr_index), .wr_data(wr_data), .priv_machine(priv_machine),
    .wr_accept(wr_accept), .cfg_bus(cfg_bus), .addr_bus(addr_bus),
    .active_rules(active_rules), .any_locked(any_locked), .check_req(check_req)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cfg_of(input int i);
    return cfg_bus[i*8 +: 8];
  endfunction

  function automatic logic [AW-1:0] addr_of(input int i);
    return addr_bus[i*AW +: AW];
  endfunction

  // drive after a falling edge, read accept in-cycle, read state at next falling edge
  task automatic do_write(input logic sel, input int idx, input logic [AW-1:0] data,
                          output logic acc);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = sel; wr_index = IW'(idx); wr_data = data;
    #1 acc = wr_accept;
    @(posedge clk);
    #1 wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R8 active after reset", 64'(active_rules), 0);
    check("R8 locked after reset", 64'(any_locked), 0);
    check("R9 check_req idle", 64'(check_req), 0);
    check("R5 no accept when idle", 64'(wr_accept), 0);
  endtask

  task automatic t_basic_writes();
    logic acc;
    do_write(1'b0, 0, 16'h000B, acc);            // TOR + R + W
    check("R5 cfg accept", 64'(acc), 1);
    check("R5 cfg0 value", 64'(cfg_of(0)), 64'h0B);
    check("R6 one active", 64'(active_rules), 1);
    do_write(1'b1, 1, 16'h1234, acc);
    check("R5 addr accept", 64'(acc), 1);
    check("R5 addr1 value", 64'(addr_of(1)), 64'h1234);
  endtask

  task automatic t_out_of_range();
    logic acc;
    logic [N*8-1:0]  c0;
    logic [N*AW-1:0] a0;
    c0 = cfg_bus; a0 = addr_bus;
    do_write(1'b0, 4, 16'h0098, acc);
    check("R1 cfg idx 4 refused", 64'(acc), 0);
    do_write(1'b1, 7, 16'hBEEF, acc);
    check("R1 addr idx 7 refused", 64'(acc), 0);
    check("R1 cfg unchanged", 64'(cfg_bus), 64'(c0));
    check("R1 addr unchanged", 64'(addr_bus), 64'(a0));
  endtask

  task automatic t_lock_rules();
    logic acc;
    do_write(1'b0, 3, 16'h0090, acc);            // locked NA4
    check("R7 lock visible", 64'(any_locked), 1);
    do_write(1'b1, 2, 16'h2222, acc);
    check("R4 locked NA4 above allows", 64'(acc), 1);
    check("R4 addr2 written", 64'(addr_of(2)), 64'h2222);
    do_write(1'b0, 1, 16'h0008, acc);            // TOR unlocked
    do_write(1'b1, 0, 16'h0100, acc);
    check("R4 unlocked TOR above allows", 64'(acc), 1);
    do_write(1'b0, 2, 16'h008D, acc);            // lock + TOR + R + X
    check("R2 lock write accepted", 64'(acc), 1);
    do_write(1'b0, 2, 16'h0000, acc);
    check("R2 locked cfg refused", 64'(acc), 0);
    check("R2 cfg2 kept", 64'(cfg_of(2)), 64'h8D);
    do_write(1'b1, 2, 16'h5555, acc);
    check("R3 locked addr refused", 64'(acc), 0);
    check("R3 addr2 kept", 64'(addr_of(2)), 64'h2222);
    do_write(1'b1, 1, 16'h6666, acc);
    check("R4 locked TOR above refuses", 64'(acc), 0);
    check("R4 addr1 kept", 64'(addr_of(1)), 64'h1234);
    check("R6 four active", 64'(active_rules), 4);
  endtask

  task automatic t_check_priv();
    @(negedge clk) priv_machine = 1'b0;
    #1 check("R9 user mode", 64'(check_req), 1);
    @(negedge clk) priv_machine = 1'b1;
    #1 check("R9 machine with lock", 64'(check_req), 1);
  endtask

  task automatic t_reset_keep();
    logic [N*AW-1:0] a0;
    logic acc;
    a0 = addr_bus;
    @(negedge clk);
    rst = 1'b1; wr_valid = 1'b1; wr_sel = 1'b1; wr_index = '0; wr_data = 16'hAAAA;
    #1 check("R8 no accept in reset", 64'(wr_accept), 0);
    @(posedge clk);
    #1 begin rst = 1'b0; wr_valid = 1'b0; end
    @(negedge clk);
    check("R8 cfg0 keeps RW", 64'(cfg_of(0)), 64'h03);
    check("R8 cfg1 cleared", 64'(cfg_of(1)), 64'h00);
    check("R8 cfg2 keeps RX", 64'(cfg_of(2)), 64'h05);
    check("R8 cfg3 cleared", 64'(cfg_of(3)), 64'h00);
    check("R8 addr kept", 64'(addr_bus), 64'(a0));
    check("R8 active zero", 64'(active_rules), 0);
    check("R7 lock cleared", 64'(any_locked), 0);
    do_write(1'b0, 2, 16'h0018, acc);            // NAPOT, unlocked
    check("R2 unlocked after reset", 64'(acc), 1);
    check("R9 machine no lock", 64'(check_req), 0);
    priv_machine = 1'b0;
    #1 check("R9 user after reset", 64'(check_req), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset_state();
    t_basic_writes();
    t_out_of_range();
    t_lock_rules();
    t_check_priv();
    t_reset_keep();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule